// File: doc/BRIEF.md
# Dual-Channel Indirect Register Interface

This block is the byte-wide bus slave of a two-channel serial controller. Each channel exposes a control port and a data port. Behind each control port sit sixteen write registers and a small set of read registers, reached through a per-channel pointer. A control write made while the pointer is zero is a command byte: it loads the next pointer and may select the upper register bank. The next control access then hits the chosen register, and the pointer falls back to zero.

Writing the reset field of register 9 resets one channel or, with both bits set, performs a full hardware reset of both channels. Each kind of reset applies its own set of per-register masks. From the stored configuration the block derives each channel's line settings: parity, stop bits, character width, the total baud divisor, and the receive-enable, transmit-enable and loopback flags. Serial shifting, interrupt handling and the receive data path sit in neighbouring blocks. Data-port accesses are accepted but do not change any state here.

Top module: `serial_regif`

## Requirements
- R1: A control write while a channel's pointer is 0 loads that pointer from data bits [2:0]. When bits [5:3] hold code 1 (byte value 0x08 in that field), 8 is added, so registers 8 to 15 can be reached. Every other code leaves the pointer in the low bank.
- R2: A control write to a nonzero pointer returns that channel's pointer to 0. Any control read also returns it to 0. Control reads return the read register that the pointer selects.
- R3: With `swapSel` low, `busAddr[0]` selects the port (0 control, 1 data) and `busAddr[1]` selects the channel (1 = channel A, 0 = channel B). With `swapSel` high the two bits exchange roles. Per-channel output vectors use index 1 for channel A and index 0 for channel B. An access to one channel leaves the other channel's outputs unchanged.
- R4: A write to register 9 with bits [7:6] = 01 resets channel B, with 10 resets channel A, and with 11 hardware-resets both channels. The reset is the same whichever channel's port carries the write. With 00, the byte is stored and nothing is reset.
- R5: A channel reset clears receive enable (register 3 bit 0) and transmit enable (register 5 bit 3). It keeps the data-bits field of register 5 and forces register 4 bit 2 to 1. It clears loopback (register 14 bit 4) and forces register 15 to 0xF8. In read register 0 it keeps bits 0xB8 and sets 0x04 and 0x40. Read registers 12 and 13 are kept.
- R6: A hardware reset applies the channel reset and then also clears register 10. It sets register 11 to 0x08 and register 9 to 0xC0 plus its old bits 0x03. It sets register 14 to 0x30 plus its old bits 0xC0, so loopback is on afterwards.
- R7: Writes to registers 12 and 13 are also stored into read registers 12 and 13.
- R8: `baudDiv` = ({reg13, reg12} + 2) times the clock mode selected by register 4 bits [7:6]: 00 = 1, 01 = 16, 10 = 32, 11 = 64.
- R9: `dataBits` decodes register 5 bits [6:5] as 00 = 5, 01 = 7, 10 = 6, 11 = 8. Register 4 bit 0 enables parity and bit 1 selects even parity. `twoStop` is set when register 4 bits [3:2] = 11. `rxEnable` is register 3 bit 0, `txEnable` is register 5 bit 3, and `loopback` is register 14 bit 4.
- R10: Writing register 3 with bit 4 (hunt) set sets bit 4 (sync) of read register 0.
- R11: After power-on reset all write registers are 0 and read register 0 holds 0x04. Read registers other than 0, 12 and 13 always read 0.
- R12: Data-port accesses change no register and no pointer. A data-port read returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-on reset |
| swapSel | input | 1 | Exchanges the port-select and channel-select address bits |
| busValid | input | 1 | Access strobe, one cycle per access |
| busWrite | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Port and channel select bits |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the access cycle |
| parityEn | output | 2 | Parity enable per channel |
| parityEven | output | 2 | Even parity per channel |
| twoStop | output | 2 | Two stop bits per channel |
| dataBits | output | 8 | Character width per channel, 4 bits each |
| baudDiv | output | 46 | Total baud divisor per channel, 23 bits each |
| rxEnable | output | 2 | Receive enable per channel |
| txEnable | output | 2 | Transmit enable per channel |
| loopback | output | 2 | Local loopback per channel |

## Verification
The assertions assume that the bus carries at most one access per cycle. They also assume that `busAddr`, `busWrite` and `busWdata` are stable while `busValid` is high, and that `swapSel` only changes between accesses. The stimulus drives every access for exactly one cycle just after a clock edge and inserts an idle cycle between accesses. It changes `swapSel` only while the bus is idle. Reset commands are issued only through register 9 writes that follow a command byte, as the pointer protocol requires.

// File: rtl/serial_regif_pkg.sv
package serial_regif_pkg;
  localparam int DATA_W   = 8;
  localparam int N_REG    = 16;
  localparam int IDX_W    = $clog2(N_REG);
  localparam int N_CH     = 2;
  localparam int MODE_SH  = 6;
  localparam int BAUD_W   = 2 * DATA_W + 1 + MODE_SH;

  localparam logic [DATA_W-1:0] KEEP_R1      = 8'h24;
  localparam logic [DATA_W-1:0] KEEP_R5      = 8'h61;
  localparam logic [DATA_W-1:0] SOFT_R15     = 8'hF8;
  localparam logic [DATA_W-1:0] KEEP_ST      = 8'hB8;
  localparam logic [DATA_W-1:0] SET_ST       = 8'h44;
  localparam logic [DATA_W-1:0] PWR_ST       = 8'h04;
  localparam logic [DATA_W-1:0] HARD_R11     = 8'h08;

  typedef struct packed {
    logic [N_CH-1:0]   wrChan;
    logic [N_CH-1:0]   rstChan;
    logic              rstHard;
    logic              rdCtl;
    logic              chan;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] data;
  } regStb_t;
endpackage

// File: rtl/serial_regif_ctrl.sv
module serial_regif_ctrl
  import serial_regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              swapSel,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic [1:0]        busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output regStb_t           stb
);
  logic selPort, selChan, ctlAcc, ctlWrite, regWrite, isRst;
  logic [IDX_W-1:0] ptrQ [N_CH];
  logic [IDX_W-1:0] curPtr, loadPtr;

  assign selPort  = swapSel ? busAddr[1] : busAddr[0];
  assign selChan  = swapSel ? busAddr[0] : busAddr[1];
  assign ctlAcc   = busValid && !selPort;
  assign ctlWrite = ctlAcc && busWrite;
  assign curPtr   = ptrQ[selChan];
  assign regWrite = ctlWrite && (curPtr != '0);
  assign isRst    = regWrite && (curPtr == IDX_W'(9)) && (busWdata[7:6] != 2'b00);
  assign loadPtr  = {busWdata[5:3] == 3'd1, busWdata[2:0]};

  always_comb begin
    stb         = '0;
    stb.chan    = selChan;
    stb.idx     = curPtr;
    stb.data    = busWdata;
    stb.rdCtl   = ctlAcc && !busWrite;
    stb.rstHard = isRst && (busWdata[7:6] == 2'b11);
    if (isRst) stb.rstChan = {busWdata[7], busWdata[6]};
    if (regWrite && !isRst) stb.wrChan[selChan] = 1'b1;
  end

  for (genvar c = 0; c < N_CH; c++) begin : g_ptr
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) ptrQ[c] <= '0;
      else if (stb.rstChan[c]) ptrQ[c] <= '0;
      else if (ctlAcc && selChan == c) begin
        if (busWrite && ptrQ[c] == '0) ptrQ[c] <= loadPtr;
        else ptrQ[c] <= '0;
      end
    end

    p_ptr_load_r1: assert property (@(posedge clk) disable iff (!rstN)
      (ctlWrite && selChan == c && ptrQ[c] == '0) |=>
      ptrQ[c] == {$past(busWdata[5:3]) == 3'd1, $past(busWdata[2:0])});

    p_ptr_return_r2: assert property (@(posedge clk) disable iff (!rstN)
      (ctlAcc && selChan == c && (!busWrite || ptrQ[c] != '0)) |=> ptrQ[c] == '0);

    p_data_port_r12: assert property (@(posedge clk) disable iff (!rstN)
      (busValid && selPort) |=> $stable(ptrQ[c]));
  end
endmodule

// File: rtl/serial_regif_dp.sv
module serial_regif_dp
  import serial_regif_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  regStb_t                stb,
  output logic [DATA_W-1:0]      busRdata,
  output logic [N_CH-1:0]        parityEn,
  output logic [N_CH-1:0]        parityEven,
  output logic [N_CH-1:0]        twoStop,
  output logic [N_CH*4-1:0]      dataBits,
  output logic [N_CH*BAUD_W-1:0] baudDiv,
  output logic [N_CH-1:0]        rxEnable,
  output logic [N_CH-1:0]        txEnable,
  output logic [N_CH-1:0]        loopback
);
  logic [DATA_W-1:0] chanRd [N_CH];

  for (genvar c = 0; c < N_CH; c++) begin : g_chan
    logic [DATA_W-1:0] wrQ [N_REG];
    logic [DATA_W-1:0] rr0Q, rr12Q, rr13Q;
    logic [2*DATA_W:0] baseDiv;
    logic [BAUD_W-1:0] fullDiv;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < N_REG; i++) wrQ[i] <= '0;
        rr0Q  <= PWR_ST;
        rr12Q <= '0;
        rr13Q <= '0;
      end else if (stb.rstChan[c]) begin
        wrQ[1]  <= wrQ[1] & KEEP_R1;
        wrQ[3]  <= wrQ[3] & 8'hFE;
        wrQ[4]  <= wrQ[4] | 8'h04;
        wrQ[5]  <= wrQ[5] & KEEP_R5;
        wrQ[15] <= SOFT_R15;
        rr0Q    <= (rr0Q & KEEP_ST) | SET_ST;
        if (stb.rstHard) begin
          wrQ[9]  <= (wrQ[9] & 8'h03) | 8'hC0;
          wrQ[10] <= '0;
          wrQ[11] <= HARD_R11;
          wrQ[14] <= (wrQ[14] & 8'hC0) | 8'h30;
        end else begin
          wrQ[9]  <= wrQ[9] & 8'hDF;
          wrQ[10] <= wrQ[10] & 8'h60;
          wrQ[14] <= (wrQ[14] & 8'hC3) | 8'h20;
        end
      end else if (stb.wrChan[c]) begin
        wrQ[stb.idx] <= stb.data;
        if (stb.idx == IDX_W'(3) && stb.data[4]) rr0Q <= rr0Q | 8'h10;
        if (stb.idx == IDX_W'(12)) rr12Q <= stb.data;
        if (stb.idx == IDX_W'(13)) rr13Q <= stb.data;
      end
    end

    always_comb begin
      case (stb.idx)
        IDX_W'(0):  chanRd[c] = rr0Q;
        IDX_W'(12): chanRd[c] = rr12Q;
        IDX_W'(13): chanRd[c] = rr13Q;
        default:    chanRd[c] = '0;
      endcase
    end

    assign baseDiv = {1'b0, wrQ[13], wrQ[12]} + (2*DATA_W+1)'(2);
    always_comb begin
      case (wrQ[4][7:6])
        2'b00:   fullDiv = BAUD_W'(baseDiv);
        2'b01:   fullDiv = BAUD_W'(baseDiv) << 4;
        2'b10:   fullDiv = BAUD_W'(baseDiv) << 5;
        default: fullDiv = BAUD_W'(baseDiv) << 6;
      endcase
    end

    assign baudDiv[c*BAUD_W +: BAUD_W] = fullDiv;
    assign parityEn[c]   = wrQ[4][0];
    assign parityEven[c] = wrQ[4][1];
    assign twoStop[c]    = (wrQ[4][3:2] == 2'b11);
    assign rxEnable[c]   = wrQ[3][0];
    assign txEnable[c]   = wrQ[5][3];
    assign loopback[c]   = wrQ[14][4];
    always_comb begin
      case (wrQ[5][6:5])
        2'b00:   dataBits[c*4 +: 4] = 4'd5;
        2'b01:   dataBits[c*4 +: 4] = 4'd7;
        2'b10:   dataBits[c*4 +: 4] = 4'd6;
        default: dataBits[c*4 +: 4] = 4'd8;
      endcase
    end

    p_chan_rst_r5: assert property (@(posedge clk) disable iff (!rstN)
      stb.rstChan[c] |=> (wrQ[15] == SOFT_R15) && rr0Q[2] && rr0Q[6] && !wrQ[3][0]);

    p_hard_vals_r6: assert property (@(posedge clk) disable iff (!rstN)
      stb.rstHard |=> (wrQ[11] == HARD_R11) && (wrQ[10] == '0) &&
                      (wrQ[9][7:6] == 2'b11) && (wrQ[14][5:4] == 2'b11));

    p_baud_mirror_r7: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrChan[c] && stb.idx == IDX_W'(12)) |=> rr12Q == $past(stb.data));

    p_hunt_sync_r10: assert property (@(posedge clk) disable iff (!rstN)
      (stb.wrChan[c] && stb.idx == IDX_W'(3) && stb.data[4]) |=> rr0Q[4]);
  end

  assign busRdata = stb.rdCtl ? chanRd[stb.chan] : '0;
endmodule

// File: rtl/serial_regif.sv
module serial_regif
  import serial_regif_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   swapSel,
  input  logic                   busValid,
  input  logic                   busWrite,
  input  logic [1:0]             busAddr,
  input  logic [DATA_W-1:0]      busWdata,
  output logic [DATA_W-1:0]      busRdata,
  output logic [N_CH-1:0]        parityEn,
  output logic [N_CH-1:0]        parityEven,
  output logic [N_CH-1:0]        twoStop,
  output logic [N_CH*4-1:0]      dataBits,
  output logic [N_CH*BAUD_W-1:0] baudDiv,
  output logic [N_CH-1:0]        rxEnable,
  output logic [N_CH-1:0]        txEnable,
  output logic [N_CH-1:0]        loopback
);
  regStb_t stb;

  serial_regif_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .swapSel(swapSel), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata), .stb(stb)
  );

  serial_regif_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .busRdata(busRdata),
    .parityEn(parityEn), .parityEven(parityEven), .twoStop(twoStop),
    .dataBits(dataBits), .baudDiv(baudDiv), .rxEnable(rxEnable),
    .txEnable(txEnable), .loopback(loopback)
  );
endmodule

// File: tb/sim_serial_regif.sv
`timescale 1ns/1ps
module sim_serial_regif;
  localparam int BW = 23;
  localparam logic CHA = 1'b1;
  localparam logic CHB = 1'b0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic swapSel = 1'b0;
  logic busValid = 1'b0;
  logic busWrite = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [1:0] parityEn, parityEven, twoStop, rxEnable, txEnable, loopback;
  logic [7:0] dataBits;
  logic [2*BW-1:0] baudDiv;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] expQ[$];
  string tagQ[$];

  always #2 clk = ~clk;

  serial_regif u0 (
    .clk(clk), .rstN(rstN), .swapSel(swapSel), .busValid(busValid),
    .busWrite(busWrite), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .parityEn(parityEn), .parityEven(parityEven),
    .twoStop(twoStop), .dataBits(dataBits), .baudDiv(baudDiv),
    .rxEnable(rxEnable), .txEnable(txEnable), .loopback(loopback)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compares every read against the scoreboard queue
  always @(negedge clk) begin
    if (busValid && !busWrite) begin
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read actual 0x%0h expected none", busRdata);
      end else begin
        automatic logic [7:0] e = expQ.pop_front();
        automatic string t = tagQ.pop_front();
        chk(t, 32'(busRdata), 32'(e));
      end
    end
  end

  function automatic logic [1:0] ctlA(input logic ch);
    return swapSel ? {1'b0, ch} : {ch, 1'b0};
  endfunction
  function automatic logic [1:0] datA(input logic ch);
    return swapSel ? {1'b1, ch} : {ch, 1'b1};
  endfunction

  task automatic busOp(input logic wr, input logic [1:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    busValid = 1'b1; busWrite = wr; busAddr = a; busWdata = d;
    @(posedge clk); #1;
    busValid = 1'b0; busWrite = 1'b0;
  endtask

  task automatic expectRd(input logic [1:0] a, input logic [7:0] e, input string tag);
    expQ.push_back(e);
    tagQ.push_back(tag);
    busOp(1'b0, a, 8'h00);
  endtask

  task automatic setPtr(input logic ch, input int idx);
    busOp(1'b1, ctlA(ch), (idx >= 8) ? (8'h08 | 8'(idx & 7)) : 8'(idx));
  endtask

  task automatic wrReg(input logic ch, input int idx, input logic [7:0] v);
    setPtr(ch, idx);
    busOp(1'b1, ctlA(ch), v);
  endtask

  task automatic rdReg(input logic ch, input int idx, input logic [7:0] e, input string tag);
    setPtr(ch, idx);
    expectRd(ctlA(ch), e, tag);
  endtask

  function automatic logic [31:0] bd(input logic ch);
    return 32'(baudDiv[ch*BW +: BW]);
  endfunction
  function automatic logic [31:0] db(input logic ch);
    return 32'(dataBits[ch*4 +: 4]);
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R11 power-on state
    rdReg(CHA, 0, 8'h04, "R11 rr0 A");
    rdReg(CHB, 0, 8'h04, "R11 rr0 B");
    rdReg(CHA, 12, 8'h00, "R11 rr12 A");
    chk("R11 baud A", bd(CHA), 32'd2);
    chk("R11 databits B", db(CHB), 32'd5);
    chk("R11 rxEnable", 32'(rxEnable), 32'd0);

    // R7 mirror, R8 baud
    wrReg(CHA, 12, 8'h34);
    wrReg(CHA, 13, 8'h12);
    rdReg(CHA, 12, 8'h34, "R7 rr12 A");
    rdReg(CHA, 13, 8'h12, "R7 rr13 A");
    rdReg(CHA, 5, 8'h00, "R11 rr5 reads zero");
    chk("R8 baud x1", bd(CHA), 32'h1236);
    chk("R3 other channel baud", bd(CHB), 32'd2);

    // R1 pointer bank select, R2 pointer return
    busOp(1'b1, ctlA(CHA), 8'h0C);
    expectRd(ctlA(CHA), 8'h34, "R1 high bank pointer");
    expectRd(ctlA(CHA), 8'h04, "R2 read returns pointer to 0");
    busOp(1'b1, ctlA(CHA), 8'h14);
    expectRd(ctlA(CHA), 8'h00, "R1 code 2 stays low bank");

    // R8 / R9 line parameters
    wrReg(CHA, 4, 8'h43);
    chk("R8 baud x16", bd(CHA), 32'h12360);
    chk("R9 parity en", 32'(parityEn), 32'b10);
    chk("R9 parity even", 32'(parityEven), 32'b10);
    chk("R9 one stop", 32'(twoStop), 32'b00);
    wrReg(CHA, 4, 8'h8D);
    chk("R8 baud x32", bd(CHA), 32'h246C0);
    wrReg(CHA, 4, 8'hCD);
    chk("R8 baud x64", bd(CHA), 32'h48D80);
    chk("R9 two stop", 32'(twoStop), 32'b10);
    chk("R9 odd parity", 32'(parityEven), 32'b00);
    wrReg(CHA, 5, 8'h28);
    chk("R9 7 bits", db(CHA), 32'd7);
    chk("R9 tx enable", 32'(txEnable), 32'b10);
    wrReg(CHA, 5, 8'h40);
    chk("R9 6 bits", db(CHA), 32'd6);
    wrReg(CHA, 5, 8'h60);
    chk("R9 8 bits", db(CHA), 32'd8);
    chk("R3 channel B untouched", db(CHB), 32'd5);

    // R3 swapped decode, R12 data port
    swapSel = 1'b1;
    rdReg(CHA, 12, 8'h34, "R3 swapped control read A");
    expectRd(datA(CHA), 8'h00, "R12 data read zero");
    setPtr(CHA, 12);
    busOp(1'b1, datA(CHA), 8'hFF);
    expectRd(ctlA(CHA), 8'h34, "R12 data write keeps pointer");
    swapSel = 1'b0;
    rdReg(CHA, 0, 8'h04, "R12 data write keeps status");

    // R10 hunt
    wrReg(CHA, 3, 8'h11);
    rdReg(CHA, 0, 8'h14, "R10 sync bit");
    chk("R9 rx enable", 32'(rxEnable), 32'b10);

    // R4 / R5 channel A reset, issued through channel B
    wrReg(CHA, 4, 8'h08);
    wrReg(CHA, 5, 8'h28);
    wrReg(CHB, 3, 8'h01);
    wrReg(CHB, 9, 8'h80);
    chk("R5 rx cleared A", 32'(rxEnable), 32'b01);
    chk("R5 tx cleared A", 32'(txEnable), 32'b00);
    chk("R5 stop forced", 32'(twoStop), 32'b10);
    chk("R5 databits kept", db(CHA), 32'd7);
    rdReg(CHA, 0, 8'h54, "R5 status after reset");
    rdReg(CHA, 12, 8'h34, "R5 rr12 kept");

    // R4 field 00 stores only; field 01 resets B
    wrReg(CHA, 3, 8'h01);
    wrReg(CHB, 14, 8'h10);
    chk("R9 loopback B", 32'(loopback), 32'b01);
    wrReg(CHA, 9, 8'h01);
    chk("R4 field 00 no reset", 32'(rxEnable), 32'b11);
    wrReg(CHA, 9, 8'h40);
    chk("R4 B reset rx", 32'(rxEnable), 32'b10);
    chk("R5 loopback cleared", 32'(loopback), 32'b00);
    rdReg(CHB, 0, 8'h44, "R5 status B");

    // R6 hardware reset
    wrReg(CHA, 14, 8'h00);
    wrReg(CHA, 9, 8'hC0);
    chk("R6 loopback both", 32'(loopback), 32'b11);
    chk("R6 rx cleared", 32'(rxEnable), 32'b00);
    rdReg(CHA, 0, 8'h54, "R6 status A");
    rdReg(CHB, 0, 8'h44, "R6 status B");
    rdReg(CHA, 13, 8'h12, "R6 rr13 kept");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule